// File: doc/BRIEF.md
# Indirect-Addressed Register File

This block is the data memory of a small 8-bit controller with a 7-bit address space. It contains two pointer registers, a band of reserved addresses and a general-purpose RAM at the top of the map. One port carries a direct address and a read result. On a clock edge the same port can write a whole byte, set one bit or clear one bit.

Two addresses have no storage of their own. An access to either one is redirected through one of the pointer registers. Pointer A sits at 01h and serves address 00h. Pointer B sits at 03h and serves address 02h. Redirection goes one level only. If a pointer names either phantom address, reads return zero and writes are dropped. The pointers are ordinary entries of the map, so they can be loaded, read and bit-modified like RAM.

A read is combinational from the address. A write or bit operation completes in the clock cycle in which its strobe is high.

Top module: `rf_data_mem`

## Requirements
- R1: Addresses 28h to 7Fh are general-purpose RAM. `rdata` shows the byte at `addr` in the same cycle. A write with `wr_en` stores `wdata` at the next rising clock edge.
- R2: An access to 00h uses the 7-bit value of pointer A (address 01h) as its real address. An access to 02h uses pointer B (address 03h). This holds for reads, byte writes and bit operations.
- R3: Each pointer holds 7 bits. Bit 7 of 01h and 03h always reads 0, and any write or bit set to that bit is lost.
- R4: When an access through 00h or 02h resolves to 00h or 02h, it reads 00h. A write or bit operation of that kind changes no pointer and no RAM byte.
- R5: Addresses 04h to 27h are reserved. They read 00h, and writes or bit operations to them have no effect.
- R6: `bit_set` sets bit `bit_idx` (0 = LSB) of the resolved location in one clock and leaves its other bits unchanged.
- R7: `bit_clr` clears bit `bit_idx` of the resolved location in one clock and leaves its other bits unchanged.
- R8: When several strobes are high together, `wr_en` takes priority over `bit_set`, and `bit_set` takes priority over `bit_clr`.
- R9: A synchronous `rst` clears both pointers. RAM contents survive reset. A pointer changes only when it is the resolved target of a write or bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 7 | Direct address |
| wdata | input | 8 | Byte write data |
| wr_en | input | 1 | Byte write strobe |
| bit_set | input | 1 | Bit set strobe |
| bit_clr | input | 1 | Bit clear strobe |
| bit_idx | input | 3 | Bit index for set or clear |
| rdata | output | 8 | Read data of the resolved location |

## Verification
The bench aims at pointers loaded with phantom addresses. A design that followed a second level of redirection would return a pointer's contents or some RAM byte instead of zero, and a design that kept phantom writes would corrupt a pointer. It loads a pointer with FFh and sets bit 7 directly. A design with an 8-bit pointer would then read back a nonzero MSB and send later indirect accesses outside the map. It also raises strobes together and writes into the reserved band. A wrong priority order, or reserved storage that was not meant to exist, then shows up as a changed byte. The bench resets in the middle of the run, which exposes RAM that is wrongly cleared.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  // Map positions the decode relies on.
  localparam int PHA_ADDR  = 'h00;
  localparam int PTRA_ADDR = 'h01;
  localparam int PHB_ADDR  = 'h02;
  localparam int PTRB_ADDR = 'h03;
  localparam int GP_BASE   = 'h28;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PTRA = 2'd1,
    TGT_PTRB = 2'd2,
    TGT_RAM  = 2'd3
  } tgt_e;
endpackage

// File: rtl/rf_addr_resolve.sv
`timescale 1ns/1ps
module rf_addr_resolve
  import rf_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  output logic [AW-1:0] eff,
  output logic          is_ind,
  output logic          is_phantom,
  output tgt_e          tgt
);
  localparam logic [AW-1:0] PHA  = AW'(PHA_ADDR);
  localparam logic [AW-1:0] PHB  = AW'(PHB_ADDR);
  localparam logic [AW-1:0] PTRA = AW'(PTRA_ADDR);
  localparam logic [AW-1:0] PTRB = AW'(PTRB_ADDR);
  localparam logic [AW-1:0] BASE = AW'(GP_BASE);

  // One level of redirection only; a second phantom hit is a dead access.
  always_comb begin
    is_ind     = (addr == PHA) || (addr == PHB);
    eff        = (addr == PHA) ? ptr_a : (addr == PHB) ? ptr_b : addr;
    is_phantom = (eff == PHA) || (eff == PHB);
    if (is_phantom)        tgt = TGT_NONE;
    else if (eff == PTRA)  tgt = TGT_PTRA;
    else if (eff == PTRB)  tgt = TGT_PTRB;
    else if (eff >= BASE)  tgt = TGT_RAM;
    else                   tgt = TGT_NONE;
  end
endmodule

// File: rtl/rf_ptr_pair.sv
`timescale 1ns/1ps
module rf_ptr_pair #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int NPTR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPTR-1:0] we,
  input  logic [DW-1:0]   wval,
  output logic [AW-1:0]   ptr [NPTR]
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)        ptr[g] <= '0;
      else if (we[g]) ptr[g] <= wval[AW-1:0];
    end

    // R9: a pointer moves only when it is the resolved write target
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
      !we[g] |=> $stable(ptr[g]))
      else $error("pointer %0d changed without a write", g);
  end
endmodule

// File: rtl/rf_gp_ram.sv
`timescale 1ns/1ps
module rf_gp_ram #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int BASE = 'h28
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wval,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rval
);
  localparam int DEPTH = (1 << AW) - BASE;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] woff, roff;

  assign woff = waddr - BASE_A;
  assign roff = raddr - BASE_A;

  // No reset: contents survive rst (R9).
  always_ff @(posedge clk) begin
    if (we) mem[woff[IW-1:0]] <= wval;
  end

  assign rval = (raddr >= BASE_A) ? mem[roff[IW-1:0]] : '0;
endmodule

// File: rtl/rf_data_mem.sv
`timescale 1ns/1ps
module rf_data_mem
  import rf_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          bit_set,
  input  logic          bit_clr,
  input  logic [BW-1:0] bit_idx,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] RSV_LO = AW'(PTRB_ADDR + 1);
  localparam logic [AW-1:0] RSV_HI = AW'(GP_BASE - 1);

  // Byte write beats bit set beats bit clear.
  function automatic logic [DW-1:0] merge_op(
    input logic [DW-1:0] cur, input logic [DW-1:0] wd,
    input logic we, input logic bs, input logic bc, input logic [BW-1:0] idx);
    logic [DW-1:0] m;
    m      = '0;
    m[idx] = 1'b1;
    if (we) return wd;
    if (bs) return cur | m;
    if (bc) return cur & ~m;
    return cur;
  endfunction

  logic [AW-1:0] eff;
  logic          is_ind, is_phantom;
  tgt_e          tgt;
  logic [AW-1:0] ptr [2];
  logic [DW-1:0] ram_rd, cur_val, next_val;
  logic          any_wr, ram_we;
  logic [1:0]    ptr_we;

  rf_addr_resolve #(.AW(AW)) u_res (
    .addr(addr), .ptr_a(ptr[0]), .ptr_b(ptr[1]),
    .eff(eff), .is_ind(is_ind), .is_phantom(is_phantom), .tgt(tgt)
  );

  rf_ptr_pair #(.AW(AW), .DW(DW), .NPTR(2)) u_ptr (
    .clk(clk), .rst(rst), .we(ptr_we), .wval(next_val), .ptr(ptr)
  );

  rf_gp_ram #(.AW(AW), .DW(DW), .BASE(GP_BASE)) u_ram (
    .clk(clk), .we(ram_we), .waddr(eff), .wval(next_val),
    .raddr(eff), .rval(ram_rd)
  );

  always_comb begin
    unique case (tgt)
      TGT_PTRA: cur_val = DW'(ptr[0]);
      TGT_PTRB: cur_val = DW'(ptr[1]);
      TGT_RAM:  cur_val = ram_rd;
      default:  cur_val = '0;
    endcase
  end

  assign rdata    = cur_val;
  assign next_val = merge_op(cur_val, wdata, wr_en, bit_set, bit_clr, bit_idx);
  assign any_wr   = wr_en | bit_set | bit_clr;
  assign ptr_we   = {any_wr && (tgt == TGT_PTRB), any_wr && (tgt == TGT_PTRA)};
  assign ram_we   = any_wr && (tgt == TGT_RAM);

  // R4: a phantom resolution yields a zero read
  a_r4_phantom_reads_zero: assert property (@(posedge clk) disable iff (rst)
    is_phantom |-> (rdata == '0))
    else $error("phantom read not zero");

  // R5: reserved band reads zero
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (!is_ind && addr >= RSV_LO && addr <= RSV_HI) |-> (rdata == '0))
    else $error("reserved read not zero");

  // R3: pointer MSB is always zero
  a_r3_ptr_msb_zero: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_PTRA || tgt == TGT_PTRB) |-> (rdata[DW-1:AW] == '0))
    else $error("pointer MSB nonzero");

  // R6: a lone set only raises at most one bit
  a_r6_set_one_bit: assert property (@(posedge clk) disable iff (rst)
    (bit_set && !wr_en) |-> ($countones(next_val ^ cur_val) <= 1 && (next_val & cur_val) == cur_val))
    else $error("bit set touched other bits");

  // R7: a lone clear only drops at most one bit
  a_r7_clr_one_bit: assert property (@(posedge clk) disable iff (rst)
    (bit_clr && !bit_set && !wr_en) |-> ($countones(next_val ^ cur_val) <= 1 && (next_val | cur_val) == cur_val))
    else $error("bit clear touched other bits");
endmodule

// File: tb/sim_rf_data_mem.sv
`timescale 1ns/1ps
module sim_rf_data_mem;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rdata;

  always #2.5 clk = ~clk;

  rf_data_mem u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx), .rdata(rdata)
  );

  logic [7:0] mdl [128];
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [6:0] m_eff(input logic [6:0] a);
    if (a == 7'h00) return mdl[1][6:0];
    if (a == 7'h02) return mdl[3][6:0];
    return a;
  endfunction

  function automatic logic [7:0] m_rd(input logic [6:0] a);
    logic [6:0] e;
    e = m_eff(a);
    if (e == 7'h00 || e == 7'h02) return 8'h00;
    if (e == 7'h01 || e == 7'h03) return mdl[e] & 8'h7F;
    if (e >= 7'h28) return mdl[e];
    return 8'h00;
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic op(input logic [6:0] a, input logic [7:0] wd, input logic we,
                    input logic bs, input logic bc, input logic [2:0] idx);
    logic [6:0] e;
    logic [7:0] nv;
    @(negedge clk);
    addr = a; wdata = wd; wr_en = we; bit_set = bs; bit_clr = bc; bit_idx = idx;
    e  = m_eff(a);
    nv = m_rd(a);
    if (we)      nv = wd;
    else if (bs) nv = nv | (8'h01 << idx);
    else if (bc) nv = nv & ~(8'h01 << idx);
    @(posedge clk);
    if (e == 7'h01 || e == 7'h03) mdl[e] = nv & 8'h7F;
    else if (e >= 7'h28)          mdl[e] = nv;
    #1;
    wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic chk(input logic [6:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chkm(input logic [6:0] a, input string tag);
    chk(a, m_rd(a), tag);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    mdl[1] = 8'h00;
    mdl[3] = 8'h00;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [6:0] ra;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    do_reset();

    // R9: reset state of the pointers; R4: pointer A = 00h makes 00h dead
    chk(7'h01, 8'h00, "R9 ptrA reset");
    chk(7'h03, 8'h00, "R9 ptrB reset");
    chk(7'h00, 8'h00, "R4 phantom via zero ptr");

    // R1: fill RAM with a known pattern
    for (int a = 'h28; a < 128; a++) op(7'(a), 8'(a) ^ 8'h5A, 1'b1, 1'b0, 1'b0, 3'd0);
    chk(7'h28, 8'h28 ^ 8'h5A, "R1 low RAM");
    chk(7'h7F, 8'h7F ^ 8'h5A, "R1 high RAM");

    // R5: reserved writes lost
    op(7'h10, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0);
    op(7'h27, 8'h00, 1'b0, 1'b1, 1'b0, 3'd4);
    chk(7'h10, 8'h00, "R5 reserved 10h");
    chk(7'h27, 8'h00, "R5 reserved 27h");

    // R2: indirect through both pointers
    op(7'h01, 8'h30, 1'b1, 1'b0, 1'b0, 3'd0);
    chk(7'h00, 8'h30 ^ 8'h5A, "R2 read via ptrA");
    op(7'h00, 8'hC3, 1'b1, 1'b0, 1'b0, 3'd0);
    chk(7'h30, 8'hC3, "R2 write via ptrA");
    op(7'h03, 8'h7E, 1'b1, 1'b0, 1'b0, 3'd0);
    op(7'h02, 8'h00, 1'b0, 1'b0, 1'b1, 3'd1);
    chk(7'h7E, (8'h7E ^ 8'h5A) & ~8'h02, "R2 bit clear via ptrB");

    // R3: pointer is 7 bits wide
    op(7'h01, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0);
    chk(7'h01, 8'h7F, "R3 ptr write FF");
    chk(7'h00, 8'h7F ^ 8'h5A, "R3 ptr resolves to 7Fh");
    op(7'h03, 8'h00, 1'b0, 1'b1, 1'b0, 3'd7);
    chk(7'h03, 8'h7E, "R3 set of ptr bit7 lost");

    // R4: pointers naming phantom addresses
    op(7'h01, 8'h02, 1'b1, 1'b0, 1'b0, 3'd0);
    chk(7'h00, 8'h00, "R4 ptrA -> 02h reads zero");
    op(7'h00, 8'h55, 1'b1, 1'b0, 1'b0, 3'd0);
    op(7'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
    chk(7'h01, 8'h02, "R4 ptrA untouched");
    chk(7'h03, 8'h7E, "R4 ptrB untouched");
    chk(7'h7E, (8'h7E ^ 8'h5A) & ~8'h02, "R4 RAM untouched");
    op(7'h03, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0);
    op(7'h02, 8'hAA, 1'b1, 1'b0, 1'b0, 3'd0);
    chk(7'h02, 8'h00, "R4 ptrB -> 00h reads zero");
    chk(7'h03, 8'h00, "R4 ptrB still zero");

    // R6 / R7: direct bit operations
    op(7'h40, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0);
    op(7'h40, 8'h00, 1'b0, 1'b1, 1'b0, 3'd5);
    chk(7'h40, 8'h20, "R6 set bit5");
    op(7'h40, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0);
    op(7'h40, 8'h00, 1'b0, 1'b0, 1'b1, 3'd7);
    chk(7'h40, 8'h7F, "R7 clear bit7");

    // R8: priority of strobes
    op(7'h41, 8'h3C, 1'b1, 1'b1, 1'b1, 3'd0);
    chk(7'h41, 8'h3C, "R8 write beats bit ops");
    op(7'h41, 8'h00, 1'b0, 1'b1, 1'b1, 3'd0);
    chk(7'h41, 8'h3D, "R8 set beats clear");

    // R9: reset keeps RAM, clears pointers
    op(7'h01, 8'h41, 1'b1, 1'b0, 1'b0, 3'd0);
    do_reset();
    chk(7'h01, 8'h00, "R9 ptrA cleared");
    chk(7'h41, 8'h3D, "R9 RAM kept");
    chk(7'h30, 8'hC3, "R9 RAM kept 30h");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      logic [6:0] a;
      sel = $urandom % 10;
      if (sel < 3)      a = ($urandom % 2) ? 7'h02 : 7'h00;
      else if (sel < 4) a = ($urandom % 2) ? 7'h03 : 7'h01;
      else              a = 7'($urandom);
      op(a, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      chkm(a, "RND op addr");
      ra = 7'($urandom);
      chkm(ra, "RND other addr");
    end

    report();
    $finish;
  end
endmodule